// File: doc/BRIEF.md
# PHY Control Port Access Sequencer

This block is a hardware master that turns a single register request into the strobe-and-acknowledge handshake a PHY's control port expects. A request names an operation (address load, write or read) and a 16-bit value. The block drives a control word that carries a 16-bit data input field and four strobes. It then polls the PHY acknowledge line at spaced intervals, up to a bounded number of times. It ends with a one-cycle done pulse, which carries an error flag and, for reads, the captured PHY output word.

Each strobe moves through four phases. The strobe rises, the block waits for acknowledge high, the strobe drops, and the block waits for acknowledge low. A write runs a data-capture handshake and then a write handshake. A write whose value has bit 0 set is a PHY reset. The PHY cannot answer while it resets, so for that write the block raises the write strobe and finishes in the same step without any acknowledge wait. The gap between acknowledge samples is a parameter counted in clock cycles.

Top module: `phy_cr_seq`

## Requirements
- R1: After reset, ctrl_o is all zero, and done_o, err_o and rdata_o are zero.
- R2: For op code 0 (address), the block loads val_i into ctrl_o[15:0]. It then runs one address-capture handshake on ctrl_o[16] and ends with done_o and err_o low.
- R3: For op code 1 (write) with val_i[0] clear, the block loads val_i into ctrl_o[15:0]. It runs a data-capture handshake on ctrl_o[17] and then a write handshake on ctrl_o[18], and the PHY receives the value.
- R4: For a write with val_i[0] set, the data-capture handshake runs as usual. The write strobe ctrl_o[18] then rises in the same cycle that done_o is shown, without error. It stays high until the next request is accepted, and accepting that request clears it.
- R5: For op codes 2 and 3 (read), ctrl_o[15:0] is left unchanged. The block runs a handshake on ctrl_o[19] and returns on rdata_o the dout_i value sampled while acknowledge was high.
- R6: Acknowledge is first sampled in the cycle where the strobe change appears on ctrl_o, then every GAP_CYC cycles, for at most MAX_POLLS samples. Take an acknowledge that follows the strobes D cycles late, and let n = GAP_CYC*ceil(D/GAP_CYC)+1. Counted from the request cycle, done appears after 2+2n cycles for an address or read and after 3+4n cycles for a write.
- R7: If the expected acknowledge level is missing at the last sample, the operation ends with done_o and err_o high and all strobes low. No later strobe of that operation is raised.
- R8: At most one strobe is high at any time. The strobe bit positions are: address capture at 16, data capture at 17, write at 18, read at 19.
- R9: A request that arrives while an operation is in progress is ignored. It produces no done pulse and does not change ctrl_o[15:0].
- R10: done_o is high for exactly one cycle per operation, and err_o is high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| op_i | input | 2 | 0 address, 1 write, 2 or 3 read |
| val_i | input | DATA_W | Address or write value |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Acknowledge timeout, valid with done_o |
| rdata_o | output | DATA_W | Word captured by the last read |
| ctrl_o | output | DATA_W+4 | Control word to the PHY: data field and strobes |
| dout_i | input | DATA_W | PHY output data |
| ack_i | input | 1 | PHY acknowledge |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives exactly at the last allowed sample, next to one that arrives a single cycle too late. A second hard case is a reset write, whose write strobe is left high after done. The bench's PHY model echoes the strobes onto acknowledge with a programmable delay. It sweeps that delay from zero past the limit, (MAX_POLLS-1)*GAP_CYC, for address, write and read, and checks the exact latency or the timeout on each side of the boundary. A stuck-high acknowledge forces the timeout in the drop phase, and a reset write followed by a new request shows when the held strobe is released.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  localparam int NSTB = 4;

  // strobe index above the data field; the PHY decodes these positions
  typedef enum logic [1:0] {
    STB_ADDR = 2'd0,
    STB_DATA = 2'd1,
    STB_WR   = 2'd2,
    STB_RD   = 2'd3
  } stb_e;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RAISE,
    S_WHI,
    S_WLO
  } seq_st_e;
endpackage

// File: rtl/cr_ack_poll.sv
module cr_ack_poll #(
  parameter int MAX_POLLS = 10,
  parameter int GAP_CYC   = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic want_i,
  input  logic ack_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int TW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int SW = $clog2(MAX_POLLS + 1);

  logic [TW-1:0] tmr_q;
  logic [SW-1:0] cnt_q;
  logic          sample;

  assign sample   = active_i && (tmr_q == '0);
  assign hit_o    = sample && (ack_i == want_i);
  assign expire_o = sample && !hit_o && (cnt_q == SW'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (sample && !hit_o && !expire_o) begin
      cnt_q <= cnt_q + 1'b1;
      tmr_q <= TW'(GAP_CYC - 1);
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < SW'(MAX_POLLS));

  // R6
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GAP_CYC > 1 && sample && !hit_o && !expire_o && !start_i) |=> !sample);
endmodule

// File: rtl/cr_word_reg.sv
module cr_word_reg import phy_cr_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   din_load_i,
  input  logic [DATA_W-1:0]      din_i,
  input  logic [NSTB-1:0]        stb_set_i,
  input  logic                   stb_clr_i,
  output logic [DATA_W+NSTB-1:0] word_o
);
  logic [DATA_W-1:0] din_q;
  logic [NSTB-1:0]   stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         din_q <= '0;
    else if (din_load_i) din_q <= din_i;
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           stb_q[g] <= 1'b0;
      else if (stb_clr_i)    stb_q[g] <= 1'b0;
      else if (stb_set_i[g]) stb_q[g] <= 1'b1;
    end
  end

  assign word_o = {stb_q, din_q};

  // R8
  stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));
endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq import phy_cr_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 10,
  parameter int GAP_CYC   = 12500,
  parameter int RST_BIT   = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [1:0]             op_i,
  input  logic [DATA_W-1:0]      val_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [DATA_W+NSTB-1:0] ctrl_o,
  input  logic [DATA_W-1:0]      dout_i,
  input  logic                   ack_i
);
  localparam int WR_IDX  = DATA_W + int'(STB_WR);
  localparam int STB_LSB = DATA_W;

  seq_st_e           st_q, st_d;
  stb_e              cur_q;
  logic              rstw_q;
  logic              done_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  logic              din_load, stb_clr, poll_start, fin, fin_err;
  logic [NSTB-1:0]   stb_set;
  logic              hit, expire, want, active;

  function automatic stb_e first_stb(input logic [1:0] op);
    case (op)
      OP_ADDR:  return STB_ADDR;
      OP_WRITE: return STB_DATA;
      default:  return STB_RD;
    endcase
  endfunction

  assign want   = (st_q != S_WLO);
  assign active = (st_q == S_WHI) || (st_q == S_WLO);

  cr_ack_poll #(.MAX_POLLS(MAX_POLLS), .GAP_CYC(GAP_CYC)) u_poll (
    .clk_i, .rst_ni,
    .start_i (poll_start),
    .active_i(active),
    .want_i  (want),
    .ack_i,
    .hit_o   (hit),
    .expire_o(expire)
  );

  cr_word_reg #(.DATA_W(DATA_W)) u_word (
    .clk_i, .rst_ni,
    .din_load_i(din_load),
    .din_i     (val_i),
    .stb_set_i (stb_set),
    .stb_clr_i (stb_clr),
    .word_o    (ctrl_o)
  );

  always_comb begin
    st_d       = st_q;
    din_load   = 1'b0;
    stb_clr    = 1'b0;
    stb_set    = '0;
    poll_start = 1'b0;
    fin        = 1'b0;
    fin_err    = 1'b0;
    case (st_q)
      S_IDLE: if (req_i) begin
        stb_clr  = 1'b1;  // a held reset-write strobe is released here
        din_load = (op_i == OP_ADDR) || (op_i == OP_WRITE);
        st_d     = S_RAISE;
      end
      S_RAISE: begin
        stb_set = NSTB'(1) << cur_q;
        if (cur_q == STB_WR && rstw_q) begin
          fin  = 1'b1;    // PHY in reset cannot answer
          st_d = S_IDLE;
        end else begin
          poll_start = 1'b1;
          st_d       = S_WHI;
        end
      end
      S_WHI: if (hit) begin
        stb_clr    = 1'b1;
        poll_start = 1'b1;
        st_d       = S_WLO;
      end else if (expire) begin
        stb_clr = 1'b1;
        fin     = 1'b1;
        fin_err = 1'b1;
        st_d    = S_IDLE;
      end
      S_WLO: if (hit) begin
        if (cur_q == STB_DATA) st_d = S_RAISE;
        else begin
          fin  = 1'b1;
          st_d = S_IDLE;
        end
      end else if (expire) begin
        stb_clr = 1'b1;
        fin     = 1'b1;
        fin_err = 1'b1;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cur_q   <= STB_ADDR;
      rstw_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      err_q  <= fin_err;
      if (st_q == S_IDLE && req_i) begin
        cur_q  <= first_stb(op_i);
        rstw_q <= (op_i == OP_WRITE) && val_i[RST_BIT];
      end
      if (st_q == S_WLO && hit && cur_q == STB_DATA) cur_q <= STB_WR;
      if (st_q == S_WHI && hit && cur_q == STB_RD) rdata_q <= dout_i;
    end
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R7
  err_stb_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (ctrl_o[STB_LSB +: NSTB] == '0));

  // R4
  rst_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && ctrl_o[WR_IDX]) |-> ctrl_o[RST_BIT]);

  // R9
  busy_din_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |=> $stable(ctrl_o[DATA_W-1:0]));
endmodule

// File: tb/sim_phy_cr_seq.sv
module sim_phy_cr_seq;
  localparam int DW = 16;
  localparam int G  = 4;
  localparam int MP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [DW-1:0] val = '0;
  logic          done, err, ack;
  logic [DW-1:0] rdata, dout;
  logic [DW+3:0] ctrl;

  phy_cr_seq #(.DATA_W(DW), .MAX_POLLS(MP), .GAP_CYC(G)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .val_i(val),
    .done_o(done), .err_o(err), .rdata_o(rdata), .ctrl_o(ctrl),
    .dout_i(dout), .ack_i(ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // PHY model: ack echoes the strobe OR with a delay; small register file
  int            dly = 0;
  bit            stuck_hi = 1'b0;
  logic [63:0]   hist;
  logic [3:0]    stb_prev;
  logic [DW-1:0] paddr, pdata;
  logic [DW-1:0] mem [16];
  logic [3:0]    stb;
  logic          any_stb;

  assign stb     = ctrl[DW+3:DW];
  assign any_stb = |stb;
  assign dout    = mem[paddr[3:0]];

  always_comb begin
    if (stuck_hi)      ack = 1'b1;
    else if (dly == 0) ack = any_stb;
    else               ack = hist[dly-1];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0; stb_prev <= '0; paddr <= '0; pdata <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      hist     <= {hist[62:0], any_stb};
      stb_prev <= stb;
      if (stb[0] && !stb_prev[0]) paddr <= ctrl[DW-1:0];
      if (stb[1] && !stb_prev[1]) pdata <= ctrl[DW-1:0];
      if (stb[2] && !stb_prev[2]) mem[paddr[3:0]] <= pdata;
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d expected <150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int nwait(input int d);
    return G * ((d + G - 1) / G) + 1;
  endfunction

  function automatic bit fits(input int d);
    return d <= (MP - 1) * G;
  endfunction

  localparam int TO_LAT = 2 + (MP - 1) * G + 1;

  int         lat;
  logic       e;
  logic [3:0] sd, seen, s1;

  task automatic run_op(input logic [1:0] o, input logic [DW-1:0] v);
    @(negedge clk);
    req = 1'b1; op = o; val = v;
    lat = 0; seen = '0; s1 = '0;
    while (lat < 3000) begin
      @(negedge clk);
      lat++;
      req = 1'b0;
      seen |= stb;
      if (lat == 1) s1 = stb;
      if (done) break;
    end
    e  = err;
    sd = stb;
    @(negedge clk);
    chk("R10", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ctrl after reset", {12'd0, ctrl}, 32'd0);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
    chk("R1", "err after reset", {31'd0, err}, 32'd0);
    chk("R1", "rdata after reset", {16'd0, rdata}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "ctrl idle", {12'd0, ctrl}, 32'd0);

    // delay sweep across the acknowledge window boundary
    for (int d = 0; d <= 40; d++) begin
      logic [DW-1:0] a;
      logic [DW-1:0] w;
      a   = DW'(d);
      w   = 16'hA000 | DW'(d << 4) | 16'h0002;
      dly = d;
      run_op(2'd0, a);
      if (fits(d)) begin
        chk("R6", "addr latency", lat, 2 + 2 * nwait(d));
        chk("R2", "addr err", {31'd0, e}, 32'd0);
        chk("R8", "addr strobe bit16", {28'd0, seen}, 32'h1);
        chk("R2", "addr on data field", {16'd0, ctrl[DW-1:0]}, {16'd0, a});
      end else begin
        chk("R7", "addr timeout latency", lat, TO_LAT);
        chk("R7", "addr timeout err", {31'd0, e}, 32'd1);
        chk("R7", "strobes low at error", {28'd0, sd}, 32'd0);
      end
      idle(70);
      run_op(2'd1, w);
      if (fits(d)) begin
        chk("R6", "write latency", lat, 3 + 4 * nwait(d));
        chk("R3", "write err", {31'd0, e}, 32'd0);
        chk("R8", "write strobes 17,18", {28'd0, seen}, 32'h6);
      end else begin
        chk("R7", "write timeout latency", lat, TO_LAT);
        chk("R7", "write strobe abandoned", {28'd0, seen}, 32'h2);
        chk("R7", "write timeout err", {31'd0, e}, 32'd1);
      end
      idle(70);
      run_op(2'd2, 16'hFFFF);
      if (fits(d)) begin
        chk("R6", "read latency", lat, 2 + 2 * nwait(d));
        chk("R3", "read back written value", {16'd0, rdata}, {16'd0, w});
        chk("R5", "read leaves data field", {16'd0, ctrl[DW-1:0]}, {16'd0, w});
        chk("R8", "read strobe bit19", {28'd0, seen}, 32'h8);
      end else begin
        chk("R7", "read timeout latency", lat, TO_LAT);
        chk("R7", "read timeout err", {31'd0, e}, 32'd1);
      end
      idle(70);
    end

    // acknowledge stuck high: drop-phase timeout
    stuck_hi = 1'b1; dly = 0;
    run_op(2'd0, 16'h0009);
    chk("R7", "stuck-high latency", lat, TO_LAT + 1);
    chk("R7", "stuck-high err", {31'd0, e}, 32'd1);
    chk("R7", "stuck-high strobes low", {28'd0, sd}, 32'd0);
    stuck_hi = 1'b0;
    idle(70);

    // reset write with delayed ack
    dly = 3;
    run_op(2'd0, 16'h0006);
    idle(70);
    run_op(2'd1, 16'h0001);
    chk("R4", "reset write latency d3", lat, 3 + 2 * nwait(3));
    chk("R4", "reset write no err", {31'd0, e}, 32'd0);
    chk("R4", "write strobe at done", {28'd0, sd}, 32'h4);
    dly = 0;
    idle(70);

    // reset write, strobe held then cleared by next request
    run_op(2'd0, 16'h0005);
    run_op(2'd1, 16'h0801);
    chk("R4", "reset write latency d0", lat, 5);
    chk("R4", "write strobe at done", {28'd0, sd}, 32'h4);
    idle(10);
    chk("R4", "write strobe held", {31'd0, ctrl[DW+2]}, 32'd1);
    run_op(2'd0, 16'h0005);
    chk("R4", "strobes cleared on accept", {28'd0, s1}, 32'd0);
    chk("R2", "addr after reset write", lat, 4);
    run_op(2'd3, 16'h0000);
    chk("R5", "op3 reads", {16'd0, rdata}, 32'h0801);
    chk("R8", "op3 strobe bit19", {28'd0, seen}, 32'h8);
    chk("R5", "op3 latency", lat, 4);
    idle(10);

    // request while busy is ignored
    begin
      int ndone;
      int tdone;
      dly = 8; ndone = 0; tdone = 0;
      @(negedge clk);
      req = 1'b1; op = 2'd0; val = 16'h0003;
      for (int c = 1; c <= 40; c++) begin
        @(negedge clk);
        if (c <= 12) begin req = 1'b1; op = 2'd1; val = 16'hFFFF; end
        else req = 1'b0;
        if (done) begin ndone++; tdone = c; end
      end
      chk("R9", "single done", ndone, 1);
      chk("R9", "done cycle", tdone, 2 + 2 * nwait(8));
      chk("R9", "data field kept", {16'd0, ctrl[DW-1:0]}, 32'h0003);
    end

    summary();
    $finish;
  end
endmodule